// File: doc/BRIEF.md
# Oscillator Stabilization Wait Timer

This block keeps a "crystal clock is usable" indication low after a crystal oscillator is switched on, until the oscillator has produced a selectable power-of-two number of clock edges. Software picks the wait length with a 3-bit code held in an 8-bit register. It then clears the oscillator stop control. The block counts edges of the oscillator clock itself, so time during which the oscillator has not started toggling is never counted. Once the selected count is reached the counter holds and the stable flag rises.

A deep-sleep release pulse, received while the oscillator runs, enforces the wait a second time using whatever code the register holds at that moment. A thermometer status output shows which of the eight thresholds have been crossed so far, so software can poll progress. Register access, the stop control, the release pulse and both outputs live in the bus clock domain. The counter lives in the oscillator domain. Each crossing goes through a multi-flop synchronizer.

Top module: `osc_settle_timer`

## Requirements
- R1: A write (`wr_en`=1 for one bus clock) stores `wr_data[2:0]` as the select code. `rd_data[2:0]` returns the code and `rd_data[7:3]` always reads 0.
- R2: After reset the code is 7 (`rd_data`=8'h07), `osc_stable`=0 and `stage_done`=8'h00.
- R3: Codes 0 to 7 give waits of 2^8, 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 oscillator edges. The edges are counted from the start event. `osc_stable` is 0 four edges before that point and is 1 within 64 edges after it.
- R4: The wait starts when `osc_stop` goes from 1 to 0. While `osc_stop`=1 nothing is counted.
- R5: Once the selected count is reached, the counter holds and `osc_stable` stays 1 until a stop or a restart.
- R6: `stage_done[i]`=1 once the count has reached threshold i (thresholds in the order of R3). The vector is therefore a thermometer code, and after a completed wait with code c it equals bits 0..c set.
- R7: Setting `osc_stop`=1 clears the count, `stage_done` and `osc_stable`.
- R8: A `sleep_exit` pulse while `osc_stop`=0 restarts the wait with the code currently held in the register.
- R9: A `sleep_exit` pulse while `osc_stop`=1 has no effect.
- R10: A write during a wait in progress does not change the length of that wait.
- R11: Counting advances only on `osc_clk` edges. With the oscillator clock halted, no count accumulates, whatever the bus clock does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| osc_clk | input | 1 | Crystal oscillator clock being qualified |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data, bits 2:0 are the code |
| rd_data | output | 8 | Register read data |
| osc_stop | input | 1 | Oscillator stop control, 1 = stopped |
| sleep_exit | input | 1 | One-bus-cycle pulse on deep-sleep release |
| osc_stable | output | 1 | Selected wait has elapsed |
| stage_done | output | 8 | Thermometer of thresholds crossed |

## Verification
All seven non-default codes are run from a stop release. Each one is sampled just before and just after its nominal end, which separates the correct exponent from its neighbours at half and double the length. The reset default runs the longest wait on its own and checks that the top threshold bit is reached. Directed runs cover four cases: a code change in mid-wait, which must not alter the length; a release pulse with a new code, which must restart at the new length; a release pulse while stopped, which must do nothing; and a halted oscillator clock, which must show that only oscillator edges advance the count.

// File: rtl/ost_pkg.sv
`timescale 1ns/1ps
package ost_pkg;
   localparam int NUM_STAGES = 8;
   localparam int SEL_W      = 3;

   // exponent of the wait length for each code; the spacing is behaviour
   function automatic int stage_exp(input int idx);
      int e;
      case (idx)
         0, 1, 2, 3: e = 8 + idx;
         4, 5, 6:    e = 2 * idx + 5;
         default:    e = 18;
      endcase
      return e;
   endfunction

   localparam int MAX_EXP = 18;
   localparam int CNT_W   = MAX_EXP + 1;
endpackage

// File: rtl/ost_sync.sv
`timescale 1ns/1ps
module ost_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ost_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= RST_VAL;
         else if (s == 0)
            chain[s] <= d;
         else
            chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ost_bus_regs.sv
`timescale 1ns/1ps
module ost_bus_regs #(
   parameter int REG_W     = 8,
   parameter int SEL_W     = 3,
   parameter int RESET_SEL = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             sleep_exit,
   output logic [SEL_W-1:0] sel_q,
   output logic [REG_W-1:0] rd_data,
   output logic             wake_tgl
);
   if (REG_W < SEL_W) begin : g_bad_width
      $error("ost_bus_regs: REG_W must hold SEL_W bits");
   end

   localparam int PAD_W = REG_W - SEL_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= SEL_W'(RESET_SEL);
      else if (wr_en)
         sel_q <= wr_data[SEL_W-1:0];
   end

   // release pulse turned into a level change so a slow receiver cannot miss it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wake_tgl <= 1'b0;
      else if (sleep_exit)
         wake_tgl <= ~wake_tgl;
   end

   if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, sel_q};
   end else begin : g_nopad
      assign rd_data = sel_q;
   end

   p_sel_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (sel_q == $past(wr_data[SEL_W-1:0])));

   p_sel_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/ost_osc_counter.sv
`timescale 1ns/1ps
module ost_osc_counter
   import ost_pkg::*;
#(
   parameter int SEL_W_P  = SEL_W,
   parameter int STAGES_P = NUM_STAGES,
   parameter int CNT_W_P  = CNT_W
) (
   input  logic                osc_clk,
   input  logic                rst_n,
   input  logic                stop_s,
   input  logic                wake_s,
   input  logic [SEL_W_P-1:0]  sel_s,
   output logic                done,
   output logic [STAGES_P-1:0] stages
);
   if (STAGES_P != (1 << SEL_W_P)) begin : g_bad_stages
      $error("ost_osc_counter: stage count must match code space");
   end
   if (CNT_W_P <= MAX_EXP) begin : g_bad_cnt
      $error("ost_osc_counter: counter too narrow for longest wait");
   end

   logic [CNT_W_P-1:0] thr [STAGES_P];
   logic [CNT_W_P-1:0] cnt;
   logic [CNT_W_P-1:0] target;
   logic [SEL_W_P-1:0] run_sel;
   logic               stop_d, wake_d, active;
   logic               start_evt, wake_evt, restart;

   for (genvar g = 0; g < STAGES_P; g++) begin : g_thr
      assign thr[g]    = CNT_W_P'(1) << stage_exp(g);
      assign stages[g] = (cnt >= thr[g]);
   end

   assign target    = thr[run_sel];
   assign start_evt = stop_d & ~stop_s;
   assign wake_evt  = wake_s ^ wake_d;
   assign restart   = ~stop_s & (start_evt | wake_evt);

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_d <= 1'b1;
         wake_d <= 1'b0;
      end else begin
         stop_d <= stop_s;
         wake_d <= wake_s;
      end
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         done    <= 1'b0;
         active  <= 1'b0;
         run_sel <= '1;
      end else if (stop_s) begin
         cnt    <= '0;
         done   <= 1'b0;
         active <= 1'b0;
      end else if (restart) begin
         cnt     <= '0;
         done    <= 1'b0;
         active  <= 1'b1;
         run_sel <= sel_s;
      end else if (active && !done) begin
         cnt <= cnt + CNT_W_P'(1);
         if (cnt + CNT_W_P'(1) == target)
            done <= 1'b1;
      end
   end

   p_stop_clear_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
      stop_s |=> (cnt == '0 && !done));

   p_hold_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (done && !stop_s && !restart) |=> (done && $stable(cnt)));

   p_done_target_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
      done |-> (cnt == target));

   p_thermo_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (stages & (stages + STAGES_P'(1))) == '0);

   p_len_frozen_r10: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !restart |=> $stable(run_sel));

   p_idle_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (!active && !restart) |=> (cnt == '0));
endmodule

// File: rtl/osc_settle_timer.sv
`timescale 1ns/1ps
module osc_settle_timer
   import ost_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RESET_SEL   = 7
) (
   input  logic                  clk_bus,
   input  logic                  rst_n,
   input  logic                  osc_clk,
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wr_data,
   output logic [REG_W-1:0]      rd_data,
   input  logic                  osc_stop,
   input  logic                  sleep_exit,
   output logic                  osc_stable,
   output logic [NUM_STAGES-1:0] stage_done
);
   if (RESET_SEL < 0 || RESET_SEL >= NUM_STAGES) begin : g_bad_rst
      $error("osc_settle_timer: RESET_SEL out of code range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("osc_settle_timer: need at least two synchronizer flops");
   end

   logic [SEL_W-1:0]      sel_q, sel_s;
   logic                  wake_tgl, wake_s, stop_s, done_o;
   logic [NUM_STAGES-1:0] stages_o;

   ost_bus_regs #(.REG_W(REG_W), .SEL_W(SEL_W), .RESET_SEL(RESET_SEL)) u_regs (
      .clk(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sleep_exit(sleep_exit), .sel_q(sel_q), .rd_data(rd_data), .wake_tgl(wake_tgl));

   // bus -> oscillator domain
   ost_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stop (
      .clk(osc_clk), .rst_n(rst_n), .d(osc_stop), .q(stop_s));
   ost_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wake (
      .clk(osc_clk), .rst_n(rst_n), .d(wake_tgl), .q(wake_s));
   ost_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL(SEL_W'(RESET_SEL))) u_sync_sel (
      .clk(osc_clk), .rst_n(rst_n), .d(sel_q), .q(sel_s));

   ost_osc_counter u_cnt (
      .osc_clk(osc_clk), .rst_n(rst_n), .stop_s(stop_s), .wake_s(wake_s),
      .sel_s(sel_s), .done(done_o), .stages(stages_o));

   // oscillator -> bus domain
   ost_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
      .clk(clk_bus), .rst_n(rst_n), .d(done_o), .q(osc_stable));
   ost_sync #(.WIDTH(NUM_STAGES), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_stat (
      .clk(clk_bus), .rst_n(rst_n), .d(stages_o), .q(stage_done));

   p_rd_pad_r1: assert property (@(posedge clk_bus) disable iff (!rst_n)
      rd_data[REG_W-1:SEL_W] == '0);

   p_stable_stage_r6: assert property (@(posedge clk_bus) disable iff (!rst_n)
      (osc_stable && $stable(osc_stable) && $stable(stage_done)) |-> stage_done[0]);
endmodule

// File: tb/sim_osc_settle_timer.sv
`timescale 1ns/1ps
module sim_osc_settle_timer;
   localparam int CLK_PERIOD = 16;
   localparam int VEC_N = 7;
   localparam int VEC_CODE [VEC_N] = '{0, 1, 2, 3, 4, 5, 6};
   localparam int VEC_EXP  [VEC_N] = '{8, 9, 10, 11, 13, 15, 17};

   logic clk_bus = 1'b0, osc_clk = 1'b0, osc_run = 1'b1;
   logic rst_n = 1'b0, wr_en = 1'b0, osc_stop = 1'b1, sleep_exit = 1'b0;
   logic [7:0] wr_data = '0, rd_data, stage_done;
   logic osc_stable;
   int total = 0, bad = 0;
   bit finished = 0;

   osc_settle_timer u0 (
      .clk_bus(clk_bus), .rst_n(rst_n), .osc_clk(osc_clk), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .osc_stop(osc_stop),
      .sleep_exit(sleep_exit), .osc_stable(osc_stable), .stage_done(stage_done));

   always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
   always #1 if (osc_run) osc_clk = ~osc_clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_wait(input int n);
      repeat (n) @(posedge clk_bus);
      #2;
   endtask

   task automatic osc_wait(input int n);
      repeat (n) @(posedge osc_clk);
      #0.5;
   endtask

   task automatic reg_write(input logic [7:0] v);
      @(posedge clk_bus); #2;
      wr_en = 1'b1; wr_data = v;
      @(posedge clk_bus); #2;
      wr_en = 1'b0;
   endtask

   task automatic set_stop(input logic v);
      @(posedge clk_bus); #2;
      osc_stop = v;
   endtask

   task automatic pulse_exit();
      @(posedge clk_bus); #2;
      sleep_exit = 1'b1;
      @(posedge clk_bus); #2;
      sleep_exit = 1'b0;
   endtask

   function automatic logic [7:0] thermo(input int n);
      return 8'((16'd1 << n) - 16'd1);
   endfunction

   initial begin
      repeat (190000) @(posedge clk_bus);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bus_wait(3);
      rst_n = 1'b1;
      bus_wait(2);
      // R2 reset state
      chk("R2 rd_data", rd_data, 8'h07);
      chk("R2 stable", osc_stable, 0);
      chk("R2 status", stage_done, 0);

      // R2/R3/R6 default code 7 -> 2^18
      set_stop(1'b0);
      osc_wait((1 << 18) - 4);
      chk("R3 code7 early", osc_stable, 0);
      chk("R6 code7 early status", stage_done, 8'h7F);
      osc_wait(68);
      chk("R3 code7 late", osc_stable, 1);
      chk("R6 code7 status", stage_done, 8'hFF);
      osc_wait(500);
      chk("R5 hold", osc_stable, 1);
      set_stop(1'b1);
      bus_wait(6);
      chk("R7 stop stable", osc_stable, 0);
      chk("R7 stop status", stage_done, 0);

      // R3/R4/R6 table walk
      for (int i = 0; i < VEC_N; i++) begin
         reg_write(8'(VEC_CODE[i]));
         bus_wait(4);
         chk("R4 idle while stopped", stage_done, 0);
         set_stop(1'b0);
         osc_wait((1 << VEC_EXP[i]) - 4);
         chk("R3 early", osc_stable, 0);
         chk("R6 early status", stage_done, thermo(VEC_CODE[i]));
         osc_wait(68);
         chk("R3 late", osc_stable, 1);
         chk("R6 final status", stage_done, thermo(VEC_CODE[i] + 1));
         set_stop(1'b1);
         bus_wait(6);
         chk("R7 cleared", {23'd0, osc_stable, stage_done}, 0);
      end

      // R1 upper bits read zero
      reg_write(8'hFD);
      chk("R1 readback", rd_data, 8'h05);

      // R10 write during wait does not alter length
      reg_write(8'h00);
      bus_wait(4);
      set_stop(1'b0);
      osc_wait(50);
      reg_write(8'h07);
      chk("R1 readback 7", rd_data, 8'h07);
      osc_wait(252 - 50 - 16);
      chk("R10 early", osc_stable, 0);
      osc_wait(68);
      chk("R10 length kept", osc_stable, 1);
      set_stop(1'b1);
      bus_wait(6);

      // R8 release restarts with current code
      reg_write(8'h01);
      bus_wait(4);
      set_stop(1'b0);
      osc_wait(512 + 64);
      chk("R8 first wait", osc_stable, 1);
      reg_write(8'h02);
      bus_wait(4);
      pulse_exit();
      osc_wait(80);
      chk("R8 restart drops stable", osc_stable, 0);
      osc_wait(1024 - 4 - 80);
      chk("R8 new length early", osc_stable, 0);
      osc_wait(84);
      chk("R8 new length late", osc_stable, 1);
      chk("R8 status", stage_done, thermo(3));
      set_stop(1'b1);
      bus_wait(6);

      // R9 release while stopped is ignored
      pulse_exit();
      bus_wait(60);
      chk("R9 stable", osc_stable, 0);
      chk("R9 status", stage_done, 0);

      // R7 stop in mid-wait
      reg_write(8'h04);
      bus_wait(4);
      set_stop(1'b0);
      osc_wait(5000);
      chk("R7 mid status", stage_done, 8'h0F);
      set_stop(1'b1);
      bus_wait(6);
      chk("R7 mid cleared status", stage_done, 0);
      chk("R7 mid cleared stable", osc_stable, 0);

      // R11 halted oscillator accumulates nothing
      reg_write(8'h00);
      osc_wait(1);
      osc_run = 1'b0;
      set_stop(1'b0);
      bus_wait(100);
      chk("R11 no edges stable", osc_stable, 0);
      chk("R11 no edges status", stage_done, 0);
      osc_run = 1'b1;
      osc_wait(252);
      chk("R11 early after resume", osc_stable, 0);
      osc_wait(68);
      chk("R11 late after resume", osc_stable, 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule